// File: doc/BRIEF.md
# Fault Qualifier and Auto-Restart Latch

This block decides when a switching converter controller must stop its gate and stay in auto-restart. It takes comparator and status flags from the analog front end: feedback above the overload level, the blanking-capacitor pin above its trip level, the blanking pin pulled low as an external shutdown request, two supply overvoltage levels, over-temperature, undervoltage lockout, soft-start active and burst active. A one-microsecond strobe is the timebase for every filter window. All windows are counted only on strobe cycles.

Overload runs through two stages. The first is an internal blanking window, whose expiry releases the clamp on the blanking pin so that an external capacitor can extend the delay. The second is a short spike filter that starts once both feedback and the blanking pin are high. The other faults skip the extended blanking and use their own filters. A supply overvoltage seen during soft-start together with high feedback uses the spike filter. A sustained higher overvoltage uses a longer filter and is masked in burst mode. Over-temperature uses the spike filter. The external shutdown stops the gate at once, latches after the spike filter, and is ignored for a start-up window after each power-up. The latch stays set until undervoltage lockout, and it records the source that set it.

Top module: `fault_restart_seq`

## Requirements
- R1: After reset, with undervoltage low, restart_o, gate_stop_o, clamp_release_o are 0 and fault_src_o is 0.
- R2: clamp_release_o rises after BLANK_US strobes of continuous fb_high_i. If fb_high_i falls, the count clears and the clamp is applied again at once. A fresh full window is then needed.
- R3: The overload fault (fault_src_o bit 0) latches only after the clamp is released and fb_high_i and ba_high_i have both been held for SPIKE_US strobes. Without ba_high_i it never latches.
- R4: The soft-start overvoltage fault (bit 1) needs vcc_ov1_i, fb_high_i and softstart_i together for SPIKE_US strobes. Outside soft-start it has no effect.
- R5: The high overvoltage fault (bit 2) needs vcc_ov2_i held for OV_US continuous strobes. Any gap restarts the count, and it has no effect while burst_i is high.
- R6: Over-temperature (bit 3) latches after SPIKE_US strobes, without the overload blanking or the clamp.
- R7: The external shutdown (ba_low_i) drives gate_stop_o in the same cycle and latches (bit 4) after SPIKE_US strobes. It is ignored for the first INHIBIT_US strobes after undervoltage falls.
- R8: Once set, restart_o and fault_src_o stay frozen whatever the fault inputs do, until uvlo_i is seen. fault_src_o holds the set of sources that qualified in the setting cycle.
- R9: While uvlo_i is high, gate_stop_o is 1. One cycle later, restart_o and fault_src_o are 0.
- R10: Windows advance only on cycles where tick_us_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-microsecond strobe |
| fb_high_i | input | 1 | Feedback above overload level |
| ba_high_i | input | 1 | Blanking pin above trip level |
| ba_low_i | input | 1 | Blanking pin pulled below shutdown level |
| vcc_ov1_i | input | 1 | Supply above the lower overvoltage level |
| vcc_ov2_i | input | 1 | Supply above the upper overvoltage level |
| otp_i | input | 1 | Over-temperature |
| uvlo_i | input | 1 | Undervoltage lockout active |
| softstart_i | input | 1 | Soft-start in progress |
| burst_i | input | 1 | Burst mode active |
| clamp_release_o | output | 1 | Release clamp on blanking pin |
| gate_stop_o | output | 1 | Stop gate switching |
| restart_o | output | 1 | Auto-restart latch |
| fault_src_o | output | 5 | Latched fault sources, bit per source |

## Verification
A window counter that is off by one shows as restart_o rising one strobe early or late. The bench samples the cycle before and the cycle of the expected rise, so this error is caught inside a single window. A counter that fails to clear on a gap, or a mask that leaks, shows as a latch that should never occur, within one window length of the stimulus. A latch that does not freeze, or a wrong source mapping, shows in fault_src_o as soon as another fault is raised while the latch is set. A missing inhibit or a late shutdown path shows in gate_stop_o on the very cycle the shutdown request appears.

// File: rtl/fault_restart_pkg.sv
package fault_restart_pkg;
  localparam int NUM_SRC = 5;
  localparam int SRC_OLP = 0;
  localparam int SRC_OV1 = 1;
  localparam int SRC_OV2 = 2;
  localparam int SRC_OTP = 3;
  localparam int SRC_EXT = 4;
endpackage

// File: rtl/fr_tick_timer.sv
module fr_tick_timer #(
  parameter int LIMIT = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  // gated so a dropped condition never reports a stale expiry
  assign done_o = run_i && (cnt_q == LIM);
endmodule

// File: rtl/fr_fault_qual.sv
module fr_fault_qual
  import fault_restart_pkg::*;
#(
  parameter int BLANK_US   = 20000,
  parameter int SPIKE_US   = 30,
  parameter int OV_US      = 120,
  parameter int INHIBIT_US = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               fb_high_i,
  input  logic               ba_high_i,
  input  logic               ba_low_i,
  input  logic               vcc_ov1_i,
  input  logic               vcc_ov2_i,
  input  logic               otp_i,
  input  logic               uvlo_i,
  input  logic               softstart_i,
  input  logic               burst_i,
  output logic               clamp_release_o,
  output logic               ext_req_o,
  output logic [NUM_SRC-1:0] hit_o
);
  logic alive, inhibit_done;
  logic [NUM_SRC-1:0] cond;

  assign alive = !uvlo_i;

  fr_tick_timer #(.LIMIT(BLANK_US)) u_blank (
    .clk_i, .rst_ni, .run_i(alive && fb_high_i), .tick_i, .done_o(clamp_release_o)
  );

  fr_tick_timer #(.LIMIT(INHIBIT_US)) u_inhibit (
    .clk_i, .rst_ni, .run_i(alive), .tick_i, .done_o(inhibit_done)
  );

  assign ext_req_o = alive && ba_low_i && inhibit_done;

  always_comb begin
    cond          = '0;
    cond[SRC_OLP] = alive && clamp_release_o && fb_high_i && ba_high_i;
    cond[SRC_OV1] = alive && softstart_i && vcc_ov1_i && fb_high_i;
    cond[SRC_OV2] = alive && vcc_ov2_i && !burst_i;
    cond[SRC_OTP] = alive && otp_i;
    cond[SRC_EXT] = ext_req_o;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int LIM = (g == SRC_OV2) ? OV_US : SPIKE_US;
    fr_tick_timer #(.LIMIT(LIM)) u_filt (
      .clk_i, .rst_ni, .run_i(cond[g]), .tick_i, .done_o(hit_o[g])
    );
  end
endmodule

// File: rtl/fr_restart_latch.sv
module fr_restart_latch
  import fault_restart_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               uvlo_i,
  input  logic [NUM_SRC-1:0] hit_i,
  output logic               restart_o,
  output logic [NUM_SRC-1:0] src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      restart_o <= 1'b0;
      src_o     <= '0;
    end else if (uvlo_i) begin
      restart_o <= 1'b0;
      src_o     <= '0;
    end else if (!restart_o && |hit_i) begin
      restart_o <= 1'b1;
      src_o     <= hit_i;
    end
  end
endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq
  import fault_restart_pkg::*;
#(
  parameter int BLANK_US   = 20000,
  parameter int SPIKE_US   = 30,
  parameter int OV_US      = 120,
  parameter int INHIBIT_US = 1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_us_i,
  input  logic               fb_high_i,
  input  logic               ba_high_i,
  input  logic               ba_low_i,
  input  logic               vcc_ov1_i,
  input  logic               vcc_ov2_i,
  input  logic               otp_i,
  input  logic               uvlo_i,
  input  logic               softstart_i,
  input  logic               burst_i,
  output logic               clamp_release_o,
  output logic               gate_stop_o,
  output logic               restart_o,
  output logic [NUM_SRC-1:0] fault_src_o
);
  logic               ext_req;
  logic [NUM_SRC-1:0] hit;

  fr_fault_qual #(
    .BLANK_US(BLANK_US), .SPIKE_US(SPIKE_US), .OV_US(OV_US), .INHIBIT_US(INHIBIT_US)
  ) u_qual (
    .clk_i, .rst_ni, .tick_i(tick_us_i),
    .fb_high_i, .ba_high_i, .ba_low_i, .vcc_ov1_i, .vcc_ov2_i,
    .otp_i, .uvlo_i, .softstart_i, .burst_i,
    .clamp_release_o, .ext_req_o(ext_req), .hit_o(hit)
  );

  fr_restart_latch u_latch (
    .clk_i, .rst_ni, .uvlo_i, .hit_i(hit), .restart_o, .src_o(fault_src_o)
  );

  assign gate_stop_o = restart_o || ext_req || uvlo_i;
endmodule

// File: rtl/fault_restart_seq_chk.sv
module fault_restart_seq_chk
  import fault_restart_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fb_high_i,
  input logic               uvlo_i,
  input logic               clamp_release_o,
  input logic               gate_stop_o,
  input logic               restart_o,
  input logic [NUM_SRC-1:0] fault_src_o
);
  p_clamp_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_high_i |=> !clamp_release_o);

  p_latch_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o && !uvlo_i) |=> restart_o);

  p_src_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_o && !uvlo_i) |=> $stable(fault_src_o));

  p_src_matches_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o == (fault_src_o != '0));

  p_uvlo_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |=> (!restart_o && fault_src_o == '0));

  p_uvlo_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uvlo_i |-> gate_stop_o);

  p_latch_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> gate_stop_o);

  p_rise_needs_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restart_o) |-> $past(!uvlo_i));
endmodule

bind fault_restart_seq fault_restart_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fb_high_i(fb_high_i), .uvlo_i(uvlo_i),
  .clamp_release_o(clamp_release_o), .gate_stop_o(gate_stop_o),
  .restart_o(restart_o), .fault_src_o(fault_src_o)
);

// File: tb/fault_restart_seq_tb_top.sv
module fault_restart_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK = 40;
  localparam int SPIKE = 6;
  localparam int OV    = 10;
  localparam int INH   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_us_i = 1'b1;
  logic tick_half = 1'b0;
  logic fb_high_i = 0, ba_high_i = 0, ba_low_i = 0, vcc_ov1_i = 0, vcc_ov2_i = 0;
  logic otp_i = 0, uvlo_i = 0, softstart_i = 0, burst_i = 0;
  logic clamp_release_o, gate_stop_o, restart_o;
  logic [4:0] fault_src_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) tick_us_i <= tick_half ? ~tick_us_i : 1'b1;

  fault_restart_seq #(
    .BLANK_US(BLANK), .SPIKE_US(SPIKE), .OV_US(OV), .INHIBIT_US(INH)
  ) dut_i (
    .clk_i(clk), .rst_ni, .tick_us_i, .fb_high_i, .ba_high_i, .ba_low_i,
    .vcc_ov1_i, .vcc_ov2_i, .otp_i, .uvlo_i, .softstart_i, .burst_i,
    .clamp_release_o, .gate_stop_o, .restart_o, .fault_src_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_inputs();
    fb_high_i = 0; ba_high_i = 0; ba_low_i = 0; vcc_ov1_i = 0; vcc_ov2_i = 0;
    otp_i = 0; softstart_i = 0; burst_i = 0;
  endtask

  task automatic pwr_cycle();
    clear_inputs();
    uvlo_i = 1; step(2);
    uvlo_i = 0; step(INH + 2);
  endtask

  task automatic t_reset();
    chk("R1 restart", restart_o, 0);
    chk("R1 gate_stop", gate_stop_o, 0);
    chk("R1 clamp", clamp_release_o, 0);
    chk("R1 src", fault_src_o, 0);
    step(INH + 2);
  endtask

  task automatic t_blank();
    fb_high_i = 1; step(BLANK - 1);
    chk("R2 clamp early", clamp_release_o, 0);
    step(1);
    chk("R2 clamp release", clamp_release_o, 1);
    fb_high_i = 0; step(1);
    chk("R2 clamp reapplied", clamp_release_o, 0);
    fb_high_i = 1; step(20);
    fb_high_i = 0; step(1);
    fb_high_i = 1; step(BLANK - 1);
    chk("R2 window restarted", clamp_release_o, 0);
    step(1);
    chk("R2 full window", clamp_release_o, 1);
    chk("R3 no latch without ba_high", restart_o, 0);
    clear_inputs(); step(2);
  endtask

  task automatic t_olp();
    fb_high_i = 1; step(BLANK);
    chk("R3 clamp", clamp_release_o, 1);
    step(SPIKE + 5);
    chk("R3 fb only", restart_o, 0);
    ba_high_i = 1; step(SPIKE);
    chk("R3 spike window", restart_o, 0);
    step(1);
    chk("R3 latched", restart_o, 1);
    chk("R3 src", fault_src_o, 5'b00001);
    chk("R3 gate_stop", gate_stop_o, 1);
    clear_inputs(); otp_i = 1; step(SPIKE + 20);
    chk("R8 sticky", restart_o, 1);
    chk("R8 src frozen", fault_src_o, 5'b00001);
    uvlo_i = 1; step(1);
    chk("R9 gate during uvlo", gate_stop_o, 1);
    chk("R9 restart cleared", restart_o, 0);
    chk("R9 src cleared", fault_src_o, 0);
    otp_i = 0; uvlo_i = 0; step(1);
    chk("R9 gate after uvlo", gate_stop_o, 0);
    step(INH + 2);
  endtask

  task automatic t_ov1();
    vcc_ov1_i = 1; fb_high_i = 1; step(SPIKE + 3);
    chk("R4 outside soft-start", restart_o, 0);
    softstart_i = 1; step(SPIKE);
    chk("R4 window", restart_o, 0);
    step(1);
    chk("R4 latched", restart_o, 1);
    chk("R4 src", fault_src_o, 5'b00010);
    pwr_cycle();
  endtask

  task automatic t_ov2();
    burst_i = 1; vcc_ov2_i = 1; step(OV + 5);
    chk("R5 burst mask", restart_o, 0);
    burst_i = 0; step(OV - 1);
    vcc_ov2_i = 0; step(1);
    vcc_ov2_i = 1; step(OV);
    chk("R5 gap restarts", restart_o, 0);
    step(1);
    chk("R5 latched", restart_o, 1);
    chk("R5 src", fault_src_o, 5'b00100);
    pwr_cycle();
  endtask

  task automatic t_otp();
    otp_i = 1; step(SPIKE);
    chk("R6 window", restart_o, 0);
    step(1);
    chk("R6 latched", restart_o, 1);
    chk("R6 src", fault_src_o, 5'b01000);
    chk("R6 no clamp", clamp_release_o, 0);
    pwr_cycle();
  endtask

  task automatic t_ext();
    ba_low_i = 1; #1;
    chk("R7 immediate stop", gate_stop_o, 1);
    ba_low_i = 0; step(1);
    chk("R7 short pulse no latch", restart_o, 0);
    chk("R7 gate released", gate_stop_o, 0);
    clear_inputs();
    uvlo_i = 1; step(2);
    uvlo_i = 0; ba_low_i = 1; step(INH - 1);
    chk("R7 inhibit gate", gate_stop_o, 0);
    chk("R7 inhibit latch", restart_o, 0);
    step(1);
    chk("R7 after inhibit", gate_stop_o, 1);
    step(SPIKE);
    chk("R7 spike window", restart_o, 0);
    step(1);
    chk("R7 latched", restart_o, 1);
    chk("R7 src", fault_src_o, 5'b10000);
    pwr_cycle();
  endtask

  task automatic t_tick();
    tick_half = 1; otp_i = 1; step(SPIKE + 2);
    chk("R10 half rate not done", restart_o, 0);
    step(SPIKE + 2);
    chk("R10 half rate latched", restart_o, 1);
    tick_half = 0;
    pwr_cycle();
  endtask

  initial begin
    step(3);
    rst_ni = 1;
    step(1);
    t_reset();
    t_blank();
    t_olp();
    t_ov1();
    t_ov2();
    t_otp();
    t_ext();
    t_tick();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule